// File: doc/BRIEF.md
# PME Message Status Logger

This block sits in a PCI Express root port and keeps the record of power-management wake messages sent by a downstream device. Each time the link layer presents a decoded wake message with its 16-bit requester ID, the block either logs it as the active event, parks it as the single pending event behind the active one, or drops it when both slots are occupied. When software acknowledges the active event by writing one to its status bit, a parked event is promoted in its place and reported again.

Every logging event, whether from a fresh message or a promotion, is reported at once. It goes out as a message-signalled or pin interrupt when interrupts are enabled, or as a general-purpose-event request to the power controller when they are not. It can also latch a system-control status bit and a system-management status bit and pulse an active-low management request, each under its own enable. Enabling interrupts while an event is already logged produces a catch-up interrupt. Message parsing and interrupt delivery live outside the block.

Top module: `pme_status_logger`

## Requirements
- R1: A message arriving while the status bit is clear sets status, and the requester ID appears on `rid` in the following cycle. This counts as a logging event.
- R2: A message arriving while status is set and pending is clear sets pending and records its requester ID internally. `rid` is unchanged and no output pulse follows.
- R3: A message arriving while both status and pending are set is discarded. The internally held ID stays that of the first pending message.
- R4: Writing `clr_mask` bit 0 (status) while pending is set keeps status at 1, clears pending and loads the held ID into `rid`. This counts as a logging event.
- R5: A logging event with `int_en` high gives a one-cycle pulse in the next cycle: on `irq_msi` when `msi_en` is high, and on `irq_pin` otherwise.
- R6: A logging event with `int_en` low gives a one-cycle `gpe_msg` pulse in the next cycle and no interrupt.
- R7: A 0-to-1 change of `int_en` while status is set gives one interrupt pulse, routed as in R5. The same change while status is clear gives none.
- R8: A logging event with `sci_en` high sets `sci_sts`. Writing `clr_mask` bit 2 clears it.
- R9: A logging event with `smi_en` high sets `smi_sts` and drives `smi_n` low for one cycle. This does not depend on the other enables and may coincide with an interrupt pulse. Writing `clr_mask` bit 3 clears `smi_sts`.
- R10: Writing `clr_mask` bit 1 (pending) discards the parked message. A later status clear then leaves status clear and produces no event.
- R11: After reset, status, pending, `rid`, `sci_sts`, `smi_sts` and all pulses are 0, and `smi_n` is 1.
- R12: Every output pulse lasts exactly one cycle per cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_vld | input | 1 | Decoded wake message strobe |
| msg_rid | input | 16 | Requester ID of the message |
| clr_mask | input | 4 | Write-one-to-clear strobes: bit0 status, bit1 pending, bit2 SCI status, bit3 SMI status |
| int_en | input | 1 | Interrupt enable |
| msi_en | input | 1 | Route interrupts as MSI |
| sci_en | input | 1 | Enable SCI status setting |
| smi_en | input | 1 | Enable SMI status and request |
| sts | output | 1 | Event logged |
| pend | output | 1 | Further event parked |
| rid | output | 16 | Requester ID of the logged event |
| sci_sts | output | 1 | SCI status |
| smi_sts | output | 1 | SMI status |
| irq_pin | output | 1 | Pin interrupt pulse |
| irq_msi | output | 1 | MSI pulse |
| gpe_msg | output | 1 | General-purpose-event request pulse |
| smi_n | output | 1 | Active-low SMI request pulse |

## Verification
The bench drives a second and a third message behind a logged one, then clears status. A design that overwrote the parked ID, or that reported the second message, would show the wrong `rid` after promotion or an unexpected pulse. It raises `int_en` with status set and again with status clear. A level-sensitive design would repeat the interrupt every cycle, and an ungated one would fire without a logged event. It also fires an event with SMI and an interrupt enabled together, and clears pending before status, to catch a design that promotes a discarded message.

// File: rtl/pme_pkg.sv
package pme_pkg;
  localparam int RID_W     = 16;
  localparam int CLR_W     = 4;
  localparam int CLR_STS   = 0;
  localparam int CLR_PEND  = 1;
  localparam int CLR_SCI   = 2;
  localparam int CLR_SMI   = 3;
  typedef logic [CLR_W-1:0] pme_clr_t;
endpackage

// File: rtl/pme_log_core.sv
module pme_log_core #(
  parameter int RID_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_vld,
  input  logic [RID_W-1:0] msg_rid,
  input  logic             clr_sts,
  input  logic             clr_pend,
  output logic             sts,
  output logic             pend,
  output logic [RID_W-1:0] rid,
  output logic             log_evt
);
  logic             sts_q, pend_q, sts_d, pend_d;
  logic [RID_W-1:0] rid_q, held_q, rid_d, held_d;
  logic             eff_sts, eff_pend, promote, s1, p1, take_new, park_new;

  always_comb begin
    eff_sts  = sts_q & ~clr_sts;
    eff_pend = pend_q & ~clr_pend;
    promote  = sts_q & clr_sts & eff_pend;
    s1       = eff_sts | promote;
    p1       = eff_pend & ~promote;
    take_new = msg_vld & ~s1;
    park_new = msg_vld & s1 & ~p1;
    sts_d    = s1 | take_new;
    pend_d   = p1 | park_new;
    rid_d    = rid_q;
    held_d   = held_q;
    if (promote)  rid_d  = held_q;
    if (take_new) rid_d  = msg_rid;
    if (park_new) held_d = msg_rid;
    log_evt  = promote | take_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= 1'b0;
      pend_q <= 1'b0;
      rid_q  <= '0;
      held_q <= '0;
    end else begin
      sts_q  <= sts_d;
      pend_q <= pend_d;
      rid_q  <= rid_d;
      held_q <= held_d;
    end
  end

  assign sts  = sts_q;
  assign pend = pend_q;
  assign rid  = rid_q;

  a_r1_first_logs: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_vld && !sts_q) |=> (sts_q && rid_q == $past(msg_rid)));
  a_r2_second_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_vld && sts_q && !pend_q && !clr_sts && !clr_pend) |=> (pend_q && $stable(rid_q)));
  a_r3_third_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && pend_q && !clr_sts && !clr_pend) |=> $stable(held_q));
  a_r4_promote: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && pend_q && clr_sts && !clr_pend) |=> (sts_q && rid_q == $past(held_q)));
  a_r10_pend_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend && !clr_sts && !msg_vld) |=> !pend_q);
endmodule

// File: rtl/pme_route.sv
module pme_route (
  input  logic clk,
  input  logic rst_n,
  input  logic log_evt,
  input  logic sts,
  input  logic int_en,
  input  logic msi_en,
  input  logic sci_en,
  input  logic smi_en,
  input  logic clr_sci,
  input  logic clr_smi,
  output logic irq_pin,
  output logic irq_msi,
  output logic gpe_msg,
  output logic smi_n,
  output logic sci_sts,
  output logic smi_sts
);
  logic int_en_q, late_irq, irq_req;
  logic pin_d, msi_d, gpe_d, smip_d, sci_d, smis_d;
  logic pin_q, msi_q, gpe_q, smin_q, sci_q, smis_q;

  always_comb begin
    late_irq = int_en & ~int_en_q & sts;
    irq_req  = (log_evt & int_en) | late_irq;
    pin_d    = irq_req & ~msi_en;
    msi_d    = irq_req & msi_en;
    gpe_d    = log_evt & ~int_en;
    smip_d   = log_evt & smi_en;
    sci_d    = (sci_q & ~clr_sci) | (log_evt & sci_en);
    smis_d   = (smis_q & ~clr_smi) | smip_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en_q <= 1'b0;
      pin_q    <= 1'b0;
      msi_q    <= 1'b0;
      gpe_q    <= 1'b0;
      smin_q   <= 1'b1;
      sci_q    <= 1'b0;
      smis_q   <= 1'b0;
    end else begin
      int_en_q <= int_en;
      pin_q    <= pin_d;
      msi_q    <= msi_d;
      gpe_q    <= gpe_d;
      smin_q   <= ~smip_d;
      sci_q    <= sci_d;
      smis_q   <= smis_d;
    end
  end

  assign irq_pin = pin_q;
  assign irq_msi = msi_q;
  assign gpe_msg = gpe_q;
  assign smi_n   = smin_q;
  assign sci_sts = sci_q;
  assign smi_sts = smis_q;

  a_r5_irq_route: assert property (@(posedge clk) disable iff (!rst_n)
    (log_evt && int_en) |=> (irq_msi == $past(msi_en) && irq_pin == !$past(msi_en)));
  a_r6_gpe: assert property (@(posedge clk) disable iff (!rst_n)
    (log_evt && !int_en) |=> (gpe_msg && !irq_pin && !irq_msi));
  a_r7_late_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(int_en) && sts) |=> (irq_pin || irq_msi));
  a_r8_sci_set: assert property (@(posedge clk) disable iff (!rst_n)
    (log_evt && sci_en) |=> sci_sts);
  a_r9_smi: assert property (@(posedge clk) disable iff (!rst_n)
    (log_evt && smi_en) |=> (!smi_n && smi_sts));
  a_r12_one_route: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_pin, irq_msi, gpe_msg}));
endmodule

// File: rtl/pme_status_logger.sv
module pme_status_logger
  import pme_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_vld,
  input  logic [RID_W-1:0] msg_rid,
  input  logic [CLR_W-1:0] clr_mask,
  input  logic             int_en,
  input  logic             msi_en,
  input  logic             sci_en,
  input  logic             smi_en,
  output logic             sts,
  output logic             pend,
  output logic [RID_W-1:0] rid,
  output logic             sci_sts,
  output logic             smi_sts,
  output logic             irq_pin,
  output logic             irq_msi,
  output logic             gpe_msg,
  output logic             smi_n
);
  logic log_evt;

  pme_log_core #(.RID_W(RID_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .msg_vld  (msg_vld),
    .msg_rid  (msg_rid),
    .clr_sts  (clr_mask[CLR_STS]),
    .clr_pend (clr_mask[CLR_PEND]),
    .sts      (sts),
    .pend     (pend),
    .rid      (rid),
    .log_evt  (log_evt)
  );

  pme_route u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .log_evt (log_evt),
    .sts     (sts),
    .int_en  (int_en),
    .msi_en  (msi_en),
    .sci_en  (sci_en),
    .smi_en  (smi_en),
    .clr_sci (clr_mask[CLR_SCI]),
    .clr_smi (clr_mask[CLR_SMI]),
    .irq_pin (irq_pin),
    .irq_msi (irq_msi),
    .gpe_msg (gpe_msg),
    .smi_n   (smi_n),
    .sci_sts (sci_sts),
    .smi_sts (smi_sts)
  );
endmodule

// File: tb/test_pme_status_logger.sv
module test_pme_status_logger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_vld = 1'b0;
  logic [15:0] msg_rid = '0;
  logic [3:0]  clr_mask = '0;
  logic        int_en = 1'b0, msi_en = 1'b0, sci_en = 1'b0, smi_en = 1'b0;
  logic        sts, pend, sci_sts, smi_sts, irq_pin, irq_msi, gpe_msg, smi_n;
  logic [15:0] rid;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  typedef struct { int at; logic [3:0] vec; } exp_t;  // vec = {smi, gpe, msi, pin}
  exp_t q[$];

  pme_status_logger i_pme_status_logger (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares the pulse outputs every cycle against the queue
  always @(negedge clk) if (rst_n && !done) begin
    logic [3:0] obs, exp;
    obs = {~smi_n, gpe_msg, irq_msi, irq_pin};
    exp = 4'b0;
    if (q.size() > 0 && q[0].at == cyc) exp = q.pop_front().vec;
    if (obs != 4'b0 || exp != 4'b0) chk("R12 pulses R5 R6 R7 R9", {28'b0, obs}, {28'b0, exp});
  end

  // driver: applies one cycle of input and queues the expected pulses
  task automatic step(logic v, logic [15:0] id, logic [3:0] clr, logic [3:0] expv);
    msg_vld = v; msg_rid = id; clr_mask = clr;
    if (expv != 4'b0) q.push_back('{at: cyc + 1, vec: expv});
    @(negedge clk);
    msg_vld = 1'b0; clr_mask = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset", {sts, pend, sci_sts, smi_sts, irq_pin, irq_msi, gpe_msg, smi_n, rid},
        {8'b00000001, 16'h0});

    int_en = 1;
    step(1, 16'hA5A5, 4'b0, 4'b0001);
    chk("R1 sts", sts, 1); chk("R1 rid", rid, 16'hA5A5);
    step(1, 16'h1111, 4'b0, 4'b0);
    chk("R2 pend", pend, 1); chk("R2 rid kept", rid, 16'hA5A5);
    step(1, 16'h2222, 4'b0, 4'b0);
    chk("R3 pend", pend, 1);
    step(0, 16'h0, 4'b0001, 4'b0001);
    chk("R4 sts", sts, 1); chk("R4 pend", pend, 0);
    chk("R3 R4 rid", rid, 16'h1111);
    idle(2);

    msi_en = 1;
    step(0, 16'h0, 4'b0001, 4'b0);
    chk("R4 cleared", sts, 0);
    step(1, 16'h3333, 4'b0, 4'b0010);
    chk("R5 rid", rid, 16'h3333);
    idle(2);

    int_en = 0;
    step(0, 16'h0, 4'b0001, 4'b0);
    step(1, 16'h4444, 4'b0, 4'b0100);
    idle(2);
    // R7: enable rises while status set
    int_en = 1;
    q.push_back('{at: cyc + 1, vec: 4'b0010});
    idle(3);
    int_en = 0;
    step(0, 16'h0, 4'b0001, 4'b0);
    idle(1);
    int_en = 1;  // R7: rise with status clear, no pulse expected
    idle(3);
    chk("R7 sts clear", sts, 0);

    msi_en = 0; sci_en = 1; smi_en = 1;
    step(1, 16'h5555, 4'b0, 4'b1001);
    chk("R8 sci set", sci_sts, 1); chk("R9 smi set", smi_sts, 1);
    step(0, 16'h0, 4'b0100, 4'b0);
    chk("R8 sci clr", sci_sts, 0); chk("R9 smi held", smi_sts, 1);
    step(0, 16'h0, 4'b1000, 4'b0);
    chk("R9 smi clr", smi_sts, 0);
    sci_en = 0; smi_en = 0;

    step(1, 16'h6666, 4'b0, 4'b0);
    chk("R10 pend set", pend, 1);
    step(0, 16'h0, 4'b0010, 4'b0);
    chk("R10 pend clr", pend, 0);
    step(0, 16'h0, 4'b0001, 4'b0);
    chk("R10 sts clr", sts, 0); chk("R10 rid", rid, 16'h5555);
    idle(3);
    chk("R12 queue drained", q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule